// File: doc/BRIEF.md
# Card Clock and Power Control Unit

This unit runs in the card clock domain of an SD/SDIO host adapter. It holds the bus power phase (off, powering up, on) and enables the card bus output drivers only when the phase is on. It also makes the card clock from the adapter clock. The clock is either divided by a programmable ratio or passed straight through.

The card clock is held low after reset, while clock enable is clear, and while the bus is off or powering up. When power saving is on, the clock also stops once the command and data paths have both stayed idle for a fixed number of card clock periods. It starts again as soon as either path becomes busy.

Every start and stop takes effect only while the card clock is low, so no shortened pulse reaches the card. A one-cycle strobe marks each rising card clock edge, which lets the protocol engines step their bit counters.

Top module: `card_clk_pwr`

## Requirements
- R1: After synchronous reset the power phase reads 2'b00 (off), `pin_oe` is 0 and `card_clk` is 0.
- R2: A write with `pwr_wr` high sets the phase from `pwr_sel`: 2'b00 selects off, 2'b10 selects powering up and 2'b11 selects on. The phase is visible on `pwr_state` one cycle later. The code 2'b01 leaves the phase unchanged.
- R3: `pin_oe` is 1 exactly while the phase is on. It changes only through a power write.
- R4: `card_clk` stays low while the phase is off or powering up, or while `clk_en_sel` is 0. A high pulse already under way is allowed to finish first.
- R5: In divide mode the card clock period is `div_sel`+2 adapter cycles. Each period is high for floor((`div_sel`+2)/2) cycles and low for the remaining cycles.
- R6: In bypass mode (`bypass_sel`=1), while the clock is enabled, `card_clk` follows the adapter clock. When the clock is disabled, `card_clk` stays low.
- R7: Stopping and starting happen only while `card_clk` is low. In divide mode every high pulse lasts its full length, even when a stop request arrives during the pulse.
- R8: With `psave_sel`=1 and both `cmd_idle` and `dat_idle` high, the clock stops after exactly 8 card clock rising edges counted from the start of the idle stretch. With `psave_sel`=0 it never stops for idleness.
- R9: When either idle input drops, the idle count restarts from zero and a stopped clock starts again. Its first high cycle appears within 3 adapter cycles.
- R10: `card_clk_rise` is high for one cycle on each divided-clock rising edge, in the same cycle that `card_clk` first reads high. In bypass mode it is high on every cycle in which the clock runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Adapter clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_wr | input | 1 | Power phase write strobe |
| pwr_sel | input | 2 | Requested power phase code |
| div_sel | input | 8 | Divide value; ratio is value + 2 |
| bypass_sel | input | 1 | 1 = pass adapter clock through |
| psave_sel | input | 1 | Power-save enable |
| clk_en_sel | input | 1 | Card clock enable |
| cmd_idle | input | 1 | Command path is idle |
| dat_idle | input | 1 | Data path is idle |
| card_clk | output | 1 | Card clock |
| card_clk_rise | output | 1 | Strobe on each card clock rising edge |
| pin_oe | output | 1 | Output enable for card bus drivers |
| pwr_state | output | 2 | Current power phase code |

## Verification
The idle-expiry stop request and the divider's high phase meet in the same cycle. The eighth counted edge drops the run request while the clock is high. The bench sets both paths idle at a sample where no strobe is pending and counts the strobes that follow: it expects exactly eight, then a clock that stays low. It then makes a path busy and checks that the clock restarts within three cycles. A separate case drops the enable two cycles into a long high pulse. It passes if that pulse still measures its full length.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    typedef enum logic [1:0] {
        PH_OFF = 2'b00,
        PH_UP  = 2'b10,
        PH_ON  = 2'b11
    } phase_e;

    localparam logic [1:0] PH_RSVD = 2'b01;

    function automatic logic sel_is_valid(input logic [1:0] code);
        return code != PH_RSVD;
    endfunction

endpackage

// File: rtl/ccp_power_fsm.sv
module ccp_power_fsm
    import ccp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] sel,
    output phase_e     phase,
    output logic       oe
);

    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_OFF;
        else if (wr && sel_is_valid(sel))
            phase <= phase_e'(sel);
    end

    assign oe = (phase == PH_ON);

    a_r2_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == PH_RSVD) |=> $stable(phase));

    a_r3_oe_write_only: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(oe));

endmodule

// File: rtl/ccp_idle_mon.sv
module ccp_idle_mon #(
    parameter int IDLE_PERIODS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_idle,
    input  logic dat_idle,
    input  logic edge_tick,
    output logic idle_long
);

    localparam int CW = $clog2(IDLE_PERIODS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_PERIODS);

    logic          both_idle;
    logic [CW-1:0] cnt;

    assign both_idle = cmd_idle & dat_idle;

    always_ff @(posedge clk) begin
        if (rst || !both_idle)
            cnt <= '0;
        else if (edge_tick && cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign idle_long = both_idle && (cnt == LIMIT);

    a_r9_busy_restarts: assert property (@(posedge clk) disable iff (rst)
        !(cmd_idle && dat_idle) |=> (cnt == '0));

    a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);

endmodule

// File: rtl/ccp_clk_gen.sv
module ccp_clk_gen #(
    parameter int DIV_W      = 8,
    parameter int DIV_OFFSET = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             bypass,
    input  logic             want,
    output logic             card_clk,
    output logic             tick
);

    localparam int RW = DIV_W + 1;

    logic [RW-1:0] ratio, half, last, cnt;
    logic          run, clk_q, tick_q, byp_en, want_div;

    assign ratio    = RW'(div_sel) + RW'(DIV_OFFSET);
    assign half     = ratio >> 1;
    assign last     = ratio - RW'(1);
    assign want_div = want & ~bypass;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            cnt    <= '0;
            clk_q  <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (!run) begin
                cnt   <= '0;
                clk_q <= 1'b0;
                run   <= want_div;
            end else if (!want_div && !clk_q) begin
                run <= 1'b0;
                cnt <= '0;
            end else begin
                cnt    <= (cnt >= last) ? '0 : cnt + 1'b1;
                clk_q  <= (cnt < half);
                tick_q <= (cnt < half) && !clk_q;
            end
        end
    end

    // bypass gate enable changes only while the adapter clock is low
    always_ff @(negedge clk) begin
        if (rst)
            byp_en <= 1'b0;
        else
            byp_en <= want & bypass;
    end

    assign card_clk = bypass ? (clk & byp_en) : clk_q;
    assign tick     = bypass ? byp_en : tick_q;

    // checker state: length of current high pulse, divider held steady
    logic [RW-1:0]    hi_len;
    logic [DIV_W-1:0] div_prev;
    logic             div_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len   <= '0;
            div_prev <= '0;
            div_ok   <= 1'b0;
        end else begin
            div_prev <= div_sel;
            hi_len   <= clk_q ? hi_len + 1'b1 : '0;
            div_ok   <= clk_q ? (div_ok && div_sel == div_prev && !bypass) : 1'b1;
        end
    end

    a_r7_full_high: assert property (@(posedge clk) disable iff (rst)
        (!bypass && $fell(clk_q) && div_ok && div_sel == div_prev) |-> (hi_len == half));

    a_r10_tick_with_high: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> clk_q);

endmodule

// File: rtl/card_clk_pwr.sv
module card_clk_pwr
    import ccp_pkg::*;
#(
    parameter int DIV_W        = 8,
    parameter int DIV_OFFSET   = 2,
    parameter int IDLE_PERIODS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_wr,
    input  logic [1:0]       pwr_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             bypass_sel,
    input  logic             psave_sel,
    input  logic             clk_en_sel,
    input  logic             cmd_idle,
    input  logic             dat_idle,
    output logic             card_clk,
    output logic             card_clk_rise,
    output logic             pin_oe,
    output logic [1:0]       pwr_state
);

    phase_e phase;
    logic   idle_long, want;

    ccp_power_fsm u_pwr (
        .clk   (clk),
        .rst   (rst),
        .wr    (pwr_wr),
        .sel   (pwr_sel),
        .phase (phase),
        .oe    (pin_oe)
    );

    ccp_idle_mon #(.IDLE_PERIODS(IDLE_PERIODS)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .cmd_idle  (cmd_idle),
        .dat_idle  (dat_idle),
        .edge_tick (card_clk_rise),
        .idle_long (idle_long)
    );

    assign want = clk_en_sel && (phase == PH_ON) && !(psave_sel && idle_long);

    ccp_clk_gen #(.DIV_W(DIV_W), .DIV_OFFSET(DIV_OFFSET)) u_gen (
        .clk      (clk),
        .rst      (rst),
        .div_sel  (div_sel),
        .bypass   (bypass_sel),
        .want     (want),
        .card_clk (card_clk),
        .tick     (card_clk_rise)
    );

    assign pwr_state = phase;

    a_r4_unpowered_low: assert property (@(posedge clk) disable iff (rst)
        (!bypass_sel && phase != PH_ON && !card_clk) |=> (bypass_sel || !card_clk));

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
        (!bypass_sel && card_clk_rise) |=> (bypass_sel || !card_clk_rise));

endmodule

// File: tb/card_clk_pwr_tb.sv
module card_clk_pwr_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_wr = 1'b0;
    logic [1:0] pwr_sel = 2'b00;
    logic [7:0] div_sel = 8'd0;
    logic       bypass_sel = 1'b0, psave_sel = 1'b0, clk_en_sel = 1'b0;
    logic       cmd_idle = 1'b0, dat_idle = 1'b0;
    logic       card_clk, card_clk_rise, pin_oe;
    logic [1:0] pwr_state;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    card_clk_pwr u_dut (
        .clk(clk), .rst(rst), .pwr_wr(pwr_wr), .pwr_sel(pwr_sel),
        .div_sel(div_sel), .bypass_sel(bypass_sel), .psave_sel(psave_sel),
        .clk_en_sel(clk_en_sel), .cmd_idle(cmd_idle), .dat_idle(dat_idle),
        .card_clk(card_clk), .card_clk_rise(card_clk_rise),
        .pin_oe(pin_oe), .pwr_state(pwr_state)
    );

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_pwr(input logic [1:0] v);
        pwr_sel = v;
        pwr_wr  = 1'b1;
        step();
        pwr_wr  = 1'b0;
    endtask

    task automatic wait_high(output int waited);
        waited = 0;
        while (!card_clk && waited < 40) begin
            step();
            waited++;
        end
    endtask

    task automatic t_reset();
        chk(pwr_state == 2'b00, "R1 phase", pwr_state, 0);
        chk(pin_oe == 1'b0, "R1 oe", pin_oe, 0);
        chk(card_clk == 1'b0, "R1 clk", card_clk, 0);
    endtask

    task automatic t_power();
        clk_en_sel = 1'b1;
        wr_pwr(2'b10);
        chk(pwr_state == 2'b10, "R2 up", pwr_state, 2);
        chk(pin_oe == 1'b0, "R3 oe in up", pin_oe, 0);
        begin
            int highs = 0;
            for (int i = 0; i < 40; i++) begin
                step();
                if (card_clk) highs++;
            end
            chk(highs == 0, "R4 no clock in up", highs, 0);
        end
        wr_pwr(2'b01);
        chk(pwr_state == 2'b10, "R2 reserved", pwr_state, 2);
        wr_pwr(2'b11);
        chk(pwr_state == 2'b11, "R2 on", pwr_state, 3);
        chk(pin_oe == 1'b1, "R3 oe in on", pin_oe, 1);
        clk_en_sel = 1'b0;
        for (int i = 0; i < 5; i++) step();
    endtask

    task automatic t_divide(input int dv);
        int w, hi, lo, bad_rise;
        bit prev;
        int exp_hi, exp_lo;
        exp_hi = (dv + 2) / 2;
        exp_lo = (dv + 2) - exp_hi;
        clk_en_sel = 1'b0;
        for (int i = 0; i < 20; i++) step();
        div_sel = 8'(dv);
        clk_en_sel = 1'b1;
        prev = 1'b0;
        bad_rise = 0;
        wait_high(w);
        for (int p = 0; p < 2; p++) begin
            hi = 0;
            while (card_clk && hi < 600) begin
                if (card_clk_rise != (card_clk && !prev)) bad_rise++;
                prev = card_clk; hi++; step();
            end
            lo = 0;
            while (!card_clk && lo < 600) begin
                if (card_clk_rise) bad_rise++;
                prev = card_clk; lo++; step();
            end
            chk(hi == exp_hi, "R5 high length", hi, exp_hi);
            chk(lo == exp_lo, "R5 low length", lo, exp_lo);
        end
        chk(bad_rise == 0, "R10 strobe alignment", bad_rise, 0);
        clk_en_sel = 1'b0;
    endtask

    task automatic t_glitch();
        int w, hi, highs;
        clk_en_sel = 1'b0;
        for (int i = 0; i < 20; i++) step();
        div_sel = 8'd10;
        clk_en_sel = 1'b1;
        wait_high(w);
        hi = 0;
        for (int i = 0; i < 2; i++) begin step(); hi++; end
        clk_en_sel = 1'b0;
        while (card_clk && hi < 50) begin step(); hi++; end
        chk(hi == 6, "R7 stop during high keeps full pulse", hi, 6);
        highs = 0;
        for (int i = 0; i < 30; i++) begin step(); if (card_clk) highs++; end
        chk(highs == 0, "R4 clock stays low when disabled", highs, 0);
    endtask

    task automatic t_bypass();
        int bad;
        clk_en_sel = 1'b0;
        for (int i = 0; i < 20; i++) step();
        bypass_sel = 1'b1;
        step();
        clk_en_sel = 1'b1;
        for (int i = 0; i < 3; i++) step();
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            if (card_clk !== 1'b1) bad++;
            @(negedge clk); #1;
            if (card_clk !== 1'b0 || card_clk_rise !== 1'b1) bad++;
        end
        chk(bad == 0, "R6 bypass follows adapter clock", bad, 0);
        chk(bad == 0, "R10 bypass strobe every cycle", bad, 0);
        clk_en_sel = 1'b0;
        for (int i = 0; i < 3; i++) step();
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            if (card_clk !== 1'b0) bad++;
        end
        chk(bad == 0, "R6 bypass gated off", bad, 0);
        step();
        bypass_sel = 1'b0;
        step();
    endtask

    task automatic count_rises(input int steps, output int rises);
        rises = 0;
        for (int i = 0; i < steps; i++) begin
            step();
            if (card_clk_rise) rises++;
        end
    endtask

    task automatic t_psave();
        int r, w;
        clk_en_sel = 1'b0;
        for (int i = 0; i < 10; i++) step();
        div_sel = 8'd2;
        psave_sel = 1'b1;
        cmd_idle = 1'b0;
        dat_idle = 1'b1;
        clk_en_sel = 1'b1;
        for (int i = 0; i < 12; i++) step();
        while (card_clk_rise) step();
        cmd_idle = 1'b1;
        count_rises(80, r);
        chk(r == 8, "R8 stops after eight idle edges", r, 8);
        chk(card_clk == 1'b0, "R8 clock parked low", card_clk, 0);
        dat_idle = 1'b0;
        w = 0;
        step();
        while (!card_clk && w < 10) begin step(); w++; end
        chk(w <= 2, "R9 resumes on busy", w, 2);
        while (card_clk_rise) step();
        dat_idle = 1'b1;
        count_rises(80, r);
        chk(r == 8, "R9 idle count restarted", r, 8);
        psave_sel = 1'b0;
        count_rises(60, r);
        chk(r >= 12, "R8 no stop without power save", r, 12);
        clk_en_sel = 1'b0;
    endtask

    task automatic t_poweroff();
        int w, highs;
        div_sel = 8'd4;
        clk_en_sel = 1'b1;
        for (int i = 0; i < 10; i++) step();
        wait_high(w);
        wr_pwr(2'b00);
        chk(pin_oe == 1'b0, "R3 oe drops on off", pin_oe, 0);
        chk(pwr_state == 2'b00, "R2 off", pwr_state, 0);
        for (int i = 0; i < 6; i++) step();
        highs = 0;
        for (int i = 0; i < 30; i++) begin step(); if (card_clk) highs++; end
        chk(highs == 0, "R4 no clock when off", highs, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) step();
        rst = 1'b0;
        step();
        t_reset();
        t_power();
        t_divide(0);
        t_divide(1);
        t_divide(4);
        t_divide(7);
        t_glitch();
        t_bypass();
        t_psave();
        t_poweroff();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule